// File: doc/BRIEF.md
# SPI Controller Register and Interrupt Front-End

This block is the host-facing register side of an instruction-driven SPI controller. A simple synchronous register bus (write strobe, read strobe, byte address, 32-bit data) reaches a soft-reset control bit, a four-bit interrupt enable mask, masked and raw interrupt status views, a captured synchronisation identifier and three FIFO occupancy counters. The command FIFO, the transmit and receive data FIFOs, the serializer and the sequencer sit outside. This block turns bus accesses into single-cycle push and pop strobes toward them, and it takes their fill counts, the receive FIFO head word and the sequencer's sync report as inputs.

There are four interrupt causes. Three are FIFO watermarks that follow their FIFO state as plain levels: the command FIFO running low, the transmit FIFO running low, and the receive FIFO filling up. The fourth is a sticky flag. It is set when the sequencer reports a sync instruction, and that report also loads the instruction's 8-bit argument into the identifier register. Software clears the flag by writing a one to its bit. One level interrupt line is high while any raw cause is also enabled.

Top module: `spi_csr_frontend`

## Requirements
- R1: After the synchronous reset, the engine-reset output is 1, the enable mask is 0, the sync flag and the captured identifier are 0, `irq` is 0 and `rd_valid` is 0.
- R2: Address 0x40 holds the engine-reset control in bit 0. Writing 1 drives `engine_rst` high and writing 0 drives it low, from the cycle after the write. A read of 0x40 returns the bit. `engine_rst` does not change on any other cycle.
- R3: Address 0x80 is the enable mask in bits 3:0. It reads back exactly what was last written there, with bits 31:4 returning 0.
- R4: The cause bit positions are: bit 0 command FIFO low (`cmd_free` >= CMD_MARK), bit 1 transmit FIFO low (`tx_free` >= TX_MARK) and bit 2 receive FIFO high (`rx_level` >= RX_MARK). These three bits follow the current inputs and are not held once their condition goes away.
- R5: A cycle with `sync_valid` high sets cause bit 3 and loads `sync_id`. From the next cycle, a read of 0xC0 returns that identifier, zero-extended.
- R6: Writing 0x84 with bit 3 set clears the sync flag. Writing 0x84 with bit 3 clear leaves the flag set. If `sync_valid` arrives in the same cycle as a clearing write, the flag stays set.
- R7: `irq` is high exactly when some raw cause bit and its enable bit are both 1.
- R8: A read of 0x88 returns the raw causes in bits 3:0. A read of 0x84 returns the raw causes ANDed with the enable mask.
- R9: Reads of 0xD0, 0xD4 and 0xD8 return `cmd_free`, `tx_free` and `rx_level`, zero-extended.
- R10: A write to 0xE0 pulses `cmd_push` for that cycle, with `cmd_data` set to `wr_data` bits 15:0. A write to 0xE4 pulses `tx_push` for that cycle, with `tx_data` set to `wr_data`. No other access raises either strobe.
- R11: A read of 0xE8 returns `rx_head` and pulses `rx_pop` during the read cycle. A read of 0xEC returns `rx_head` with `rx_pop` held low.
- R12: Read data is registered. `rd_valid` and `rd_data` present the result in the cycle after the read strobe. Unmapped addresses and the two write-only ports read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| cmd_free | input | 5 | Command FIFO free entries |
| tx_free | input | 5 | Transmit FIFO free entries |
| rx_level | input | 5 | Receive FIFO filled entries |
| rx_head | input | 32 | Word at the head of the receive FIFO |
| sync_valid | input | 1 | Sequencer executed a sync instruction |
| sync_id | input | 8 | Argument of that sync instruction |
| cmd_push | output | 1 | Push strobe into the command FIFO |
| cmd_data | output | 16 | Command word to push |
| tx_push | output | 1 | Push strobe into the transmit FIFO |
| tx_data | output | 32 | Transmit word to push |
| rx_pop | output | 1 | Pop strobe on the receive FIFO |
| engine_rst | output | 1 | Holds the engine in reset while high |
| irq | output | 1 | Level interrupt |

## Verification
Each watermark is driven from below its mark to at its mark and back down. Reading it back shows a level that follows the input, not a bit that latches. The sync event is tried three ways: on its own, followed by a write of zero and then a write of one, and arriving in the same cycle as a clearing write. These cases separate a sticky flag from a level bit and show which side wins the collision. The enable mask is stepped so that the same raw causes appear masked at 0x84, unmasked at 0x88, and with the interrupt line both off and on. The receive port is read through both the popping address and the peek address, which shows that only the popping read strobes the FIFO.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int CAUSE_N = 4;

    localparam logic [BUS_AW-1:0] ADR_ENG_RST  = 8'h40;
    localparam logic [BUS_AW-1:0] ADR_IRQ_EN   = 8'h80;
    localparam logic [BUS_AW-1:0] ADR_IRQ_PEND = 8'h84;
    localparam logic [BUS_AW-1:0] ADR_IRQ_RAW  = 8'h88;
    localparam logic [BUS_AW-1:0] ADR_SYNC_TAG = 8'hC0;
    localparam logic [BUS_AW-1:0] ADR_CMD_ROOM = 8'hD0;
    localparam logic [BUS_AW-1:0] ADR_TX_ROOM  = 8'hD4;
    localparam logic [BUS_AW-1:0] ADR_RX_FILL  = 8'hD8;
    localparam logic [BUS_AW-1:0] ADR_CMD_PORT = 8'hE0;
    localparam logic [BUS_AW-1:0] ADR_TX_PORT  = 8'hE4;
    localparam logic [BUS_AW-1:0] ADR_RX_POP   = 8'hE8;
    localparam logic [BUS_AW-1:0] ADR_RX_PEEK  = 8'hEC;

    // Cause vector: the bit order is visible to software.
    typedef struct packed {
        logic sync_evt;  // bit 3
        logic rx_high;   // bit 2
        logic tx_low;    // bit 1
        logic cmd_low;   // bit 0
    } cause_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ENG_RST,
        SEL_IRQ_EN,
        SEL_IRQ_PEND,
        SEL_IRQ_RAW,
        SEL_SYNC_TAG,
        SEL_CMD_ROOM,
        SEL_TX_ROOM,
        SEL_RX_FILL,
        SEL_CMD_PORT,
        SEL_TX_PORT,
        SEL_RX_POP,
        SEL_RX_PEEK
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        case (a)
            ADR_ENG_RST:  return SEL_ENG_RST;
            ADR_IRQ_EN:   return SEL_IRQ_EN;
            ADR_IRQ_PEND: return SEL_IRQ_PEND;
            ADR_IRQ_RAW:  return SEL_IRQ_RAW;
            ADR_SYNC_TAG: return SEL_SYNC_TAG;
            ADR_CMD_ROOM: return SEL_CMD_ROOM;
            ADR_TX_ROOM:  return SEL_TX_ROOM;
            ADR_RX_FILL:  return SEL_RX_FILL;
            ADR_CMD_PORT: return SEL_CMD_PORT;
            ADR_TX_PORT:  return SEL_TX_PORT;
            ADR_RX_POP:   return SEL_RX_POP;
            ADR_RX_PEEK:  return SEL_RX_PEEK;
            default:      return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_csr_fifo_port.sv
module spi_csr_fifo_port
    import spi_csr_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int CMD_W    = 16,
    parameter int CMD_MARK = 12,
    parameter int TX_MARK  = 12,
    parameter int RX_MARK  = 4
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [BUS_DW-1:0] wr_data,
    input  logic [CNT_W-1:0]  cmd_free,
    input  logic [CNT_W-1:0]  tx_free,
    input  logic [CNT_W-1:0]  rx_level,
    output logic              cmd_push,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              tx_push,
    output logic [BUS_DW-1:0] tx_data,
    output logic              rx_pop,
    output logic [2:0]        level_cond
);

    localparam logic [CNT_W-1:0] CMD_MARK_V = CNT_W'(CMD_MARK);
    localparam logic [CNT_W-1:0] TX_MARK_V  = CNT_W'(TX_MARK);
    localparam logic [CNT_W-1:0] RX_MARK_V  = CNT_W'(RX_MARK);

    always_comb begin
        cmd_push = wr_en && (sel == SEL_CMD_PORT);
        tx_push  = wr_en && (sel == SEL_TX_PORT);
        rx_pop   = rd_en && (sel == SEL_RX_POP);
        cmd_data = wr_data[CMD_W-1:0];
        tx_data  = wr_data;
    end

    always_comb begin
        level_cond[0] = (cmd_free >= CMD_MARK_V);
        level_cond[1] = (tx_free  >= TX_MARK_V);
        level_cond[2] = (rx_level >= RX_MARK_V);
    end

endmodule

// File: rtl/spi_csr_irq.sv
module spi_csr_irq
    import spi_csr_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_sel_e           sel,
    input  logic [BUS_DW-1:0]  wr_data,
    input  logic [2:0]         level_cond,
    input  logic               sync_valid,
    input  logic [ID_W-1:0]    sync_id,
    output cause_t             raw,
    output logic [CAUSE_N-1:0] enable,
    output logic [ID_W-1:0]    sync_tag,
    output logic               irq
);

    logic sync_flag;
    logic clr_sync;

    assign clr_sync = wr_en && (sel == SEL_IRQ_PEND) && wr_data[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            enable    <= '0;
            sync_flag <= 1'b0;
            sync_tag  <= '0;
        end else begin
            if (wr_en && sel == SEL_IRQ_EN)
                enable <= wr_data[CAUSE_N-1:0];
            if (sync_valid) begin
                sync_flag <= 1'b1;
                sync_tag  <= sync_id;
            end else if (clr_sync) begin
                sync_flag <= 1'b0;
            end
        end
    end

    always_comb begin
        raw.cmd_low  = level_cond[0];
        raw.tx_low   = level_cond[1];
        raw.rx_high  = level_cond[2];
        raw.sync_evt = sync_flag;
        irq          = |(raw & enable);
    end

    // R5
    sync_capture_chk: assert property (@(posedge clk) disable iff (rst)
        sync_valid |=> (raw.sync_evt && sync_tag == $past(sync_id)));

    // R6
    sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_IRQ_PEND && wr_data[3] && !sync_valid) |=> !raw.sync_evt);

    // R6
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (raw.sync_evt && !(wr_en && sel == SEL_IRQ_PEND && wr_data[3])) |=> raw.sync_evt);

endmodule

// File: rtl/spi_csr_rdmux.sv
module spi_csr_rdmux
    import spi_csr_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int ID_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  reg_sel_e           sel,
    input  logic               eng_rst,
    input  logic [CAUSE_N-1:0] enable,
    input  cause_t             raw,
    input  logic [ID_W-1:0]    sync_tag,
    input  logic [CNT_W-1:0]   cmd_free,
    input  logic [CNT_W-1:0]   tx_free,
    input  logic [CNT_W-1:0]   rx_level,
    input  logic [BUS_DW-1:0]  rx_head,
    output logic [BUS_DW-1:0]  rd_data,
    output logic               rd_valid
);

    logic [BUS_DW-1:0] mux;

    always_comb begin
        mux = '0;
        case (sel)
            SEL_ENG_RST:  mux = BUS_DW'(eng_rst);
            SEL_IRQ_EN:   mux = BUS_DW'(enable);
            SEL_IRQ_PEND: mux = BUS_DW'(raw & enable);
            SEL_IRQ_RAW:  mux = BUS_DW'(raw);
            SEL_SYNC_TAG: mux = BUS_DW'(sync_tag);
            SEL_CMD_ROOM: mux = BUS_DW'(cmd_free);
            SEL_TX_ROOM:  mux = BUS_DW'(tx_free);
            SEL_RX_FILL:  mux = BUS_DW'(rx_level);
            SEL_RX_POP,
            SEL_RX_PEEK:  mux = rx_head;
            default:      mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= mux;
        end
    end

    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R12
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

endmodule

// File: rtl/spi_csr_frontend.sv
module spi_csr_frontend
    import spi_csr_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int CMD_W    = 16,
    parameter int ID_W     = 8,
    parameter int CMD_MARK = 12,
    parameter int TX_MARK  = 12,
    parameter int RX_MARK  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wr_data,
    output logic [BUS_DW-1:0] rd_data,
    output logic              rd_valid,
    input  logic [CNT_W-1:0]  cmd_free,
    input  logic [CNT_W-1:0]  tx_free,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [BUS_DW-1:0] rx_head,
    input  logic              sync_valid,
    input  logic [ID_W-1:0]   sync_id,
    output logic              cmd_push,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              tx_push,
    output logic [BUS_DW-1:0] tx_data,
    output logic              rx_pop,
    output logic              engine_rst,
    output logic              irq
);

    reg_sel_e           sel;
    logic [2:0]         level_cond;
    cause_t             raw;
    logic [CAUSE_N-1:0] enable;
    logic [ID_W-1:0]    sync_tag;

    assign sel = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst)
            engine_rst <= 1'b1;
        else if (wr_en && sel == SEL_ENG_RST)
            engine_rst <= wr_data[0];
    end

    spi_csr_fifo_port #(
        .CNT_W(CNT_W), .CMD_W(CMD_W),
        .CMD_MARK(CMD_MARK), .TX_MARK(TX_MARK), .RX_MARK(RX_MARK)
    ) u_port (
        .wr_en(wr_en), .rd_en(rd_en), .sel(sel), .wr_data(wr_data),
        .cmd_free(cmd_free), .tx_free(tx_free), .rx_level(rx_level),
        .cmd_push(cmd_push), .cmd_data(cmd_data),
        .tx_push(tx_push), .tx_data(tx_data),
        .rx_pop(rx_pop), .level_cond(level_cond)
    );

    spi_csr_irq #(.ID_W(ID_W)) u_irq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
        .level_cond(level_cond), .sync_valid(sync_valid), .sync_id(sync_id),
        .raw(raw), .enable(enable), .sync_tag(sync_tag), .irq(irq)
    );

    spi_csr_rdmux #(.CNT_W(CNT_W), .ID_W(ID_W)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel),
        .eng_rst(engine_rst), .enable(enable), .raw(raw), .sync_tag(sync_tag),
        .cmd_free(cmd_free), .tx_free(tx_free), .rx_level(rx_level),
        .rx_head(rx_head), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R2
    eng_rst_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == ADR_ENG_RST) |=> $stable(engine_rst));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_push, tx_push, rx_pop}));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((cmd_free >= CNT_W'(CMD_MARK) && enable[0]) ||
                 (tx_free  >= CNT_W'(TX_MARK)  && enable[1]) ||
                 (rx_level >= CNT_W'(RX_MARK)  && enable[2]) ||
                 (raw.sync_evt && enable[3])));

endmodule

// File: tb/spi_csr_frontend_tb.sv
module spi_csr_frontend_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [4:0]  cmd_free = '0, tx_free = '0, rx_level = '0;
    logic [31:0] rx_head = '0;
    logic        sync_valid = 1'b0;
    logic [7:0]  sync_id = '0;
    logic        cmd_push, tx_push, rx_pop, engine_rst, irq;
    logic [15:0] cmd_data;
    logic [31:0] tx_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    spi_csr_frontend u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .cmd_free(cmd_free), .tx_free(tx_free), .rx_level(rx_level),
        .rx_head(rx_head), .sync_valid(sync_valid), .sync_id(sync_id),
        .cmd_push(cmd_push), .cmd_data(cmd_data), .tx_push(tx_push),
        .tx_data(tx_data), .rx_pop(rx_pop), .engine_rst(engine_rst), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Driver: write, checking the FIFO push strobes during the write cycle (R10).
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        #1;
        check("R10 cmd_push", 32'(cmd_push), 32'(a == 8'hE0));
        check("R10 tx_push", 32'(tx_push), 32'(a == 8'hE4));
        if (a == 8'hE0) check("R10 cmd_data", 32'(cmd_data), {16'h0, d[15:0]});
        if (a == 8'hE4) check("R10 tx_data", tx_data, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: read; the expected value goes to the scoreboard, pop strobe checked inline (R11).
    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #1;
        check("R11 rx_pop", 32'(rx_pop), 32'(a == 8'hE8));
        check("R10 no push on read", 32'({cmd_push, tx_push}), 32'h0);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: compare read results as they come out (R12).
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected rd_valid", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 engine_rst", 32'(engine_rst), 32'h1);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 rd_valid", 32'(rd_valid), 32'h0);
        bus_read(8'h80, 32'h0, "R1 enable");
        bus_read(8'hC0, 32'h0, "R1 sync tag");
        bus_read(8'h88, 32'h0, "R1 raw causes");

        // R2 engine reset control
        bus_write(8'h40, 32'h0);
        check("R2 released", 32'(engine_rst), 32'h0);
        bus_read(8'h40, 32'h0, "R2 readback 0");
        bus_write(8'h80, 32'h0);
        check("R2 stable on other write", 32'(engine_rst), 32'h0);
        bus_write(8'h40, 32'h1);
        check("R2 held", 32'(engine_rst), 32'h1);
        bus_read(8'h40, 32'h1, "R2 readback 1");
        bus_write(8'h40, 32'h0);

        // R3 enable mask
        bus_write(8'h80, 32'hFFFF_FFFA);
        bus_read(8'h80, 32'hA, "R3 enable A");
        bus_write(8'h80, 32'h5);
        bus_read(8'h80, 32'h5, "R3 enable 5");
        bus_write(8'h80, 32'h0);

        // R9 occupancy counts
        cmd_free = 5'd16; tx_free = 5'd3; rx_level = 5'd7;
        bus_read(8'hD0, 32'd16, "R9 cmd_free");
        bus_read(8'hD4, 32'd3, "R9 tx_free");
        bus_read(8'hD8, 32'd7, "R9 rx_level");

        // R4/R8 watermark levels, raw vs masked
        rx_level = 5'd0;
        bus_read(8'h88, 32'h1, "R4 cmd low only");
        bus_read(8'h84, 32'h0, "R8 masked with enable 0");
        check("R7 irq off when masked", 32'(irq), 32'h0);
        tx_free = 5'd12; rx_level = 5'd4; cmd_free = 5'd11;
        bus_read(8'h88, 32'h6, "R4 tx low and rx high at mark");
        rx_level = 5'd3;
        bus_read(8'h88, 32'h2, "R4 rx high not sticky");
        tx_free = 5'd0;
        bus_read(8'h88, 32'h0, "R4 all levels gone");

        // R5 sync capture
        @(negedge clk);
        sync_valid = 1'b1; sync_id = 8'hA5;
        @(negedge clk);
        sync_valid = 1'b0; sync_id = 8'h00;
        bus_read(8'hC0, 32'hA5, "R5 sync tag");
        bus_read(8'h88, 32'h8, "R5 sync bit raw");

        // R7/R8 enable interplay
        check("R7 irq off, enable 0", 32'(irq), 32'h0);
        bus_write(8'h80, 32'h8);
        #1 check("R7 irq on for sync", 32'(irq), 32'h1);
        bus_read(8'h84, 32'h8, "R8 masked pending sync");
        cmd_free = 5'd20;
        bus_read(8'h84, 32'h8, "R8 cmd low masked out");
        bus_read(8'h88, 32'h9, "R8 raw shows cmd low");

        // R6 write-one-to-clear
        bus_write(8'h84, 32'h7);
        bus_read(8'h88, 32'h9, "R6 write zero keeps sync");
        bus_write(8'h84, 32'hFF);
        bus_read(8'h88, 32'h1, "R6 sync cleared");
        #1 check("R7 irq off after clear", 32'(irq), 32'h0);
        bus_write(8'h80, 32'h1);
        #1 check("R7 irq on for cmd low", 32'(irq), 32'h1);
        cmd_free = 5'd2;
        #1 check("R7 irq follows level", 32'(irq), 32'h0);

        // R6 set wins over simultaneous clear
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h84; wr_data = 32'h8;
        sync_valid = 1'b1; sync_id = 8'h3C;
        @(negedge clk);
        wr_en = 1'b0; sync_valid = 1'b0;
        bus_read(8'h88, 32'h8, "R6 set wins");
        bus_read(8'hC0, 32'h3C, "R5 second sync tag");

        // R10 FIFO write ports
        bus_write(8'hE0, 32'h1234_BEEF);
        bus_write(8'hE4, 32'hCAFE_0042);

        // R11 receive ports
        rx_head = 32'hDEAD_0001;
        bus_read(8'hEC, 32'hDEAD_0001, "R11 peek data");
        bus_read(8'hE8, 32'hDEAD_0001, "R11 pop data");

        // R12 write-only and unmapped read as zero
        bus_read(8'hE0, 32'h0, "R12 cmd port reads 0");
        bus_read(8'h44, 32'h0, "R12 unmapped reads 0");

        repeat (3) @(negedge clk);
        check("R12 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule